// File: doc/BRIEF.md
# Pixel and Scan-Line Doubler

This block lets a video source that only produces a quarter-size picture (320 columns by 240 rows) drive a display link whose smallest legal mode is 640x480 at 60 Hz. The link runs at a pixel clock of roughly 25.175 MHz. The source hands over pixels one at a time with a valid strobe. A start-of-line flag marks the first pixel of each row, and a start-of-frame flag marks the first pixel of the picture. The block turns every source pixel into a 2x2 square on the output.

Incoming rows are written into a two-bank line store, and the bank is chosen by the parity of the source row. An external 640x480 timing generator supplies an active-video flag and the current output column and row. The block reads the stored row for output row pair `y>>1`, at address `x>>1`. Each stored pixel therefore appears on two neighbouring output columns, and each stored row appears on two consecutive output lines. The output pixel and its active flag come out one clock after the timing inputs. Outside the active picture the pixel is forced to zero.

The source and the timing generator share one clock. The source is expected to finish writing row `k` before the output reaches row `2k`.

Top module: `pixel_line_doubler`

## Requirements
- R1: While reset is asserted and on the first sample after it, `out_de` is 0 and `out_pix` is all zeros.
- R2: `out_de` equals the value `tg_de` had one clock earlier.
- R3: `out_pix` is zero one clock after any cycle with `tg_de` low, or with `tg_x` >= 640, or with `tg_y` >= 480.
- R4: With `tg_de` high, `out_pix` one clock later is the stored pixel at column `tg_x>>1`, so output columns 2k and 2k+1 show the same value.
- R5: Output rows 2m and 2m+1 both read the bank given by bit 1 of `tg_y`. Bank 0 holds even source rows and bank 1 holds odd source rows.
- R6: A valid pixel with `src_sof` high makes its row source row 0, which writes to bank 0. A valid `src_sol` without `src_sof` advances the row parity by one.
- R7: A valid pixel with `src_sol` high is written to column 0, and each following valid pixel goes to the next column.
- R8: Cycles with `src_valid` low write nothing and change neither the column nor the row position, whatever `src_sol`, `src_sof` and `src_pix` show.
- R9: Valid pixels past column 319 of a row are dropped, and column 319 keeps the 320th pixel.
- R10: When a write and a read hit the same bank and column in the same cycle, the output one clock later carries the newly written pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock shared by source and timing generator |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source pixel strobe |
| src_sol | input | 1 | Marks the first pixel of a source row |
| src_sof | input | 1 | Marks the first pixel of a source frame |
| src_pix | input | 24 | Source pixel, RGB |
| tg_de | input | 1 | Active-video flag from the timing generator |
| tg_x | input | 10 | Output column from the timing generator |
| tg_y | input | 10 | Output row from the timing generator |
| out_de | output | 1 | Active-video flag, delayed one clock |
| out_pix | output | 24 | Doubled pixel, zero outside active video |

## Verification
A source write and a display read can land on the same bank and column in the same clock. This happens when the source starts a new row while the output is still scanning the matching row pair. The bench provokes it by driving a start-of-line pixel and a read of column 0 of that bank from the same falling edge, and then a second write and read pair on column 1. It judges the result by requiring the freshly written value on `out_pix`, which differs from the value the location held before.

// File: rtl/pld_pkg.sv
package pld_pkg;
   localparam int PLD_DEF_SRC_W = 320;
   localparam int PLD_DEF_SRC_H = 240;
   localparam int PLD_DEF_PIX_W = 24;
   localparam int PLD_DEF_POS_W = 10;
   localparam int PLD_NBANK     = 2;

   typedef enum logic {
      BANK_EVEN = 1'b0,
      BANK_ODD  = 1'b1
   } bank_e;

   function automatic bank_e bank_of_parity(input logic par);
      return par ? BANK_ODD : BANK_EVEN;
   endfunction
endpackage

// File: rtl/pld_src_writer.sv
module pld_src_writer
   import pld_pkg::*;
#(
   parameter int SRC_W = PLD_DEF_SRC_W,
   parameter int PIX_W = PLD_DEF_PIX_W,
   localparam int COL_W = $clog2(SRC_W),
   localparam int CNT_W = COL_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_valid,
   input  logic             src_sol,
   input  logic             src_sof,
   input  logic [PIX_W-1:0] src_pix,
   output logic             wr_en,
   output bank_e            wr_bank,
   output logic [COL_W-1:0] wr_addr,
   output logic [PIX_W-1:0] wr_data
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SRC_W);

   logic [CNT_W-1:0] col_cnt;
   logic [CNT_W-1:0] idx;
   logic             row_par;
   logic             row_par_nxt;
   logic             in_row;

   always_comb begin
      idx         = src_sol ? '0 : col_cnt;
      in_row      = idx < LAST_CNT;
      row_par_nxt = src_sof ? 1'b0 : (src_sol ? ~row_par : row_par);
      wr_en       = src_valid && in_row;
      wr_bank     = bank_of_parity(row_par_nxt);
      wr_addr     = idx[COL_W-1:0];
      wr_data     = src_pix;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_cnt <= LAST_CNT;
         row_par <= 1'b0;
      end else if (src_valid) begin
         row_par <= row_par_nxt;
         col_cnt <= in_row ? idx + CNT_W'(1) : idx;
      end
   end

   p_sof_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_sof) |=> (row_par == 1'b0));
   p_sol_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_sol && !src_sof) |=> (row_par != $past(row_par)));
   p_sol_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_sol) |=> (col_cnt == CNT_W'(1)));
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid |=> ($stable(col_cnt) && $stable(row_par)));
   p_col_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (col_cnt <= LAST_CNT));
endmodule

// File: rtl/pld_rd_map.sv
module pld_rd_map #(
   parameter int SRC_W = 320,
   parameter int SRC_H = 240,
   parameter int POS_W = 10,
   localparam int COL_W = $clog2(SRC_W)
) (
   input  logic             tg_de,
   input  logic [POS_W-1:0] tg_x,
   input  logic [POS_W-1:0] tg_y,
   output logic             rd_en,
   output logic             rd_bank,
   output logic [COL_W-1:0] rd_addr,
   output logic             rd_inrange
);
   localparam int          OUT_W = 2 * SRC_W;
   localparam int          OUT_H = 2 * SRC_H;
   localparam logic [POS_W:0] X_LIM = (POS_W+1)'(OUT_W);
   localparam logic [POS_W:0] Y_LIM = (POS_W+1)'(OUT_H);

   logic [POS_W-1:0] col;

   always_comb begin
      col        = tg_x >> 1;
      rd_inrange = tg_de && ({1'b0, tg_x} < X_LIM) && ({1'b0, tg_y} < Y_LIM);
      rd_en      = rd_inrange;
      rd_bank    = tg_y[1];
      rd_addr    = col[COL_W-1:0];
   end
endmodule

// File: rtl/pld_line_store.sv
module pld_line_store
   import pld_pkg::*;
#(
   parameter int DEPTH         = PLD_DEF_SRC_W,
   parameter int PIX_W         = PLD_DEF_PIX_W,
   parameter bit WRITE_THROUGH = 1'b1,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  bank_e            wr_bank,
   input  logic [AW-1:0]    wr_addr,
   input  logic [PIX_W-1:0] wr_data,
   input  logic             rd_en,
   input  logic             rd_bank,
   input  logic [AW-1:0]    rd_addr,
   output logic [PIX_W-1:0] rd_data
);
   logic [PIX_W-1:0] bank_q [PLD_NBANK];
   logic             sel_q;
   logic             hit;

   assign hit = rd_en && wr_en && (wr_bank == bank_e'(rd_bank)) && (wr_addr == rd_addr);

   for (genvar b = 0; b < PLD_NBANK; b++) begin : g_bank
      logic [PIX_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == bank_e'(b)))
            mem[wr_addr] <= wr_data;
      end

      always_ff @(posedge clk) begin
         if (rd_en && (rd_bank == 1'(b)))
            bank_q[b] <= mem[rd_addr];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= 1'b0;
      else if (rd_en) sel_q <= rd_bank;
   end

   if (WRITE_THROUGH) begin : g_fwd
      logic             fwd_q;
      logic [PIX_W-1:0] fwd_data_q;

      always_ff @(posedge clk) begin
         if (!rst_n) fwd_q <= 1'b0;
         else        fwd_q <= hit;
         fwd_data_q <= wr_data;
      end

      assign rd_data = fwd_q ? fwd_data_q : bank_q[sel_q];

      p_fwd_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
         hit |=> (rd_data == $past(wr_data)));
   end else begin : g_nofwd
      assign rd_data = bank_q[sel_q];
   end
endmodule

// File: rtl/pixel_line_doubler.sv
module pixel_line_doubler
   import pld_pkg::*;
#(
   parameter int SRC_W         = PLD_DEF_SRC_W,
   parameter int SRC_H         = PLD_DEF_SRC_H,
   parameter int PIX_W         = PLD_DEF_PIX_W,
   parameter int POS_W         = PLD_DEF_POS_W,
   parameter bit WRITE_THROUGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_valid,
   input  logic             src_sol,
   input  logic             src_sof,
   input  logic [PIX_W-1:0] src_pix,
   input  logic             tg_de,
   input  logic [POS_W-1:0] tg_x,
   input  logic [POS_W-1:0] tg_y,
   output logic             out_de,
   output logic [PIX_W-1:0] out_pix
);
   localparam int COL_W = $clog2(SRC_W);

   initial begin
      a_src_w: assert (SRC_W >= 2) else $error("SRC_W must be at least 2");
      a_src_h: assert (SRC_H >= 2) else $error("SRC_H must be at least 2");
      a_pos_w: assert ((1 << POS_W) >= 2 * SRC_W && (1 << POS_W) >= 2 * SRC_H)
         else $error("POS_W too narrow for the output raster");
      a_pix_w: assert (PIX_W >= 1) else $error("PIX_W must be positive");
   end

   logic             wr_en;
   bank_e            wr_bank;
   logic [COL_W-1:0] wr_addr;
   logic [PIX_W-1:0] wr_data;
   logic             rd_en;
   logic             rd_bank;
   logic [COL_W-1:0] rd_addr;
   logic             rd_inrange;
   logic [PIX_W-1:0] rd_data;
   logic             de_q;
   logic             show_q;

   pld_src_writer #(.SRC_W(SRC_W), .PIX_W(PIX_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_sol   (src_sol),
      .src_sof   (src_sof),
      .src_pix   (src_pix),
      .wr_en     (wr_en),
      .wr_bank   (wr_bank),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data)
   );

   pld_rd_map #(.SRC_W(SRC_W), .SRC_H(SRC_H), .POS_W(POS_W)) u_map (
      .tg_de      (tg_de),
      .tg_x       (tg_x),
      .tg_y       (tg_y),
      .rd_en      (rd_en),
      .rd_bank    (rd_bank),
      .rd_addr    (rd_addr),
      .rd_inrange (rd_inrange)
   );

   pld_line_store #(.DEPTH(SRC_W), .PIX_W(PIX_W), .WRITE_THROUGH(WRITE_THROUGH)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_bank (rd_bank),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         de_q   <= 1'b0;
         show_q <= 1'b0;
      end else begin
         de_q   <= tg_de;
         show_q <= rd_inrange;
      end
   end

   assign out_de  = de_q;
   assign out_pix = show_q ? rd_data : '0;

   p_de_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tg_de |=> out_de);
   p_de_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tg_de |=> !out_de);
   p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tg_de |=> (out_pix == '0));
endmodule

// File: tb/pixel_line_doubler_test.sv
module pixel_line_doubler_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_valid = 1'b0, src_sol = 1'b0, src_sof = 1'b0;
   logic [23:0] src_pix = '0;
   logic        tg_de = 1'b0;
   logic [9:0]  tg_x = '0, tg_y = '0;
   logic        out_de;
   logic [23:0] out_pix;
   int          checks = 0, failures = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   pixel_line_doubler uut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_sol(src_sol),
      .src_sof(src_sof), .src_pix(src_pix), .tg_de(tg_de), .tg_x(tg_x),
      .tg_y(tg_y), .out_de(out_de), .out_pix(out_pix)
   );

   function automatic logic [23:0] pv(input int line, input int col);
      return {8'(line + 1), 16'(col * 3 + 5)};
   endfunction

   // x[20:11], y[10:1], de[0]
   localparam logic [20:0] VEC [12] = '{
      {10'd0,   10'd0,   1'b1}, {10'd1,   10'd0,   1'b1},
      {10'd2,   10'd1,   1'b1}, {10'd3,   10'd1,   1'b1},
      {10'd639, 10'd1,   1'b1}, {10'd638, 10'd2,   1'b1},
      {10'd5,   10'd3,   1'b1}, {10'd13,  10'd478, 1'b1},
      {10'd0,   10'd479, 1'b1}, {10'd100, 10'd0,   1'b0},
      {10'd700, 10'd0,   1'b1}, {10'd4,   10'd500, 1'b1}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic v, input logic sol, input logic sof, input logic [23:0] p);
      src_valid = v; src_sol = sol; src_sof = sof; src_pix = p;
      tick();
      src_valid = 1'b0; src_sol = 1'b0; src_sof = 1'b0; src_pix = '0;
   endtask

   task automatic send_line(input logic sof, input int line, input int n);
      for (int c = 0; c < n; c++)
         push(1'b1, c == 0, sof && (c == 0), pv(line, c));
   endtask

   task automatic probe(input string req, input int x, input int y, input logic de,
                        input logic [23:0] exp);
      tg_de = de; tg_x = 10'(x); tg_y = 10'(y);
      tick();
      check(req, {23'd0, out_de}, {23'd0, de});
      check(req, out_pix, exp);
      tg_de = 1'b0; tg_x = '0; tg_y = '0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R1 de in reset", {23'd0, out_de}, 24'd0);
      check("R1 pix in reset", out_pix, 24'd0);
      rst_n = 1'b1;
      tick();
      check("R1 de after reset", {23'd0, out_de}, 24'd0);
      check("R1 pix after reset", out_pix, 24'd0);

      // rows 0 (bank 0) and 1 (bank 1)
      send_line(1'b1, 0, 320);
      send_line(1'b0, 1, 320);

      for (int i = 0; i < 12; i++) begin
         int x, y;
         logic de;
         logic [23:0] e;
         x  = int'(VEC[i][20:11]);
         y  = int'(VEC[i][10:1]);
         de = VEC[i][0];
         if (!de || x >= 640 || y >= 480) e = '0;            // R3
         else e = pv((y >> 1) & 1, x >> 1);                  // R4 R5
         probe("R2 R3 R4 R5 table", x, y, de, e);
      end

      // R8: idle cycles with markers and junk do nothing
      push(1'b1, 1'b1, 1'b0, pv(2, 0));
      push(1'b0, 1'b1, 1'b0, 24'hDEAD01);
      push(1'b0, 1'b1, 1'b1, 24'hDEAD02);
      push(1'b0, 1'b0, 1'b0, 24'hDEAD03);
      push(1'b1, 1'b0, 1'b0, pv(2, 1));
      probe("R8 col1 after idle", 2, 0, 1'b1, pv(2, 1));
      probe("R8 col0 kept", 0, 1, 1'b1, pv(2, 0));
      probe("R8 col2 untouched", 4, 0, 1'b1, pv(0, 2));

      // R6/R7: start of frame goes to bank 0 regardless of parity
      send_line(1'b1, 9, 4);
      probe("R6 R7 sof row col3", 6, 0, 1'b1, pv(9, 3));
      probe("R7 sof row col0", 1, 1, 1'b1, pv(9, 0));
      probe("R6 bank1 unchanged", 0, 3, 1'b1, pv(1, 0));
      probe("R7 beyond short row", 8, 0, 1'b1, pv(0, 4));

      // R9: overlong row into bank 1
      send_line(1'b0, 3, 322);
      probe("R9 last column kept", 639, 2, 1'b1, pv(3, 319));
      probe("R9 first column", 0, 2, 1'b1, pv(3, 0));

      // R10: write and read same location in the same cycle (bank 0)
      src_valid = 1'b1; src_sol = 1'b1; src_pix = pv(12, 0);
      tg_de = 1'b1; tg_x = 10'd0; tg_y = 10'd0;
      tick();
      check("R10 same-cycle col0", out_pix, pv(12, 0));
      src_sol = 1'b0; src_pix = pv(12, 1); tg_x = 10'd3;
      tick();
      check("R10 same-cycle col1", out_pix, pv(12, 1));
      src_valid = 1'b0; src_pix = '0; tg_de = 1'b0; tg_x = '0;
      probe("R10 stored after write", 1, 1, 1'b1, pv(12, 0));

      // R1: reset again with active video requested
      rst_n = 1'b0; tg_de = 1'b1;
      tick();
      check("R1 de under reset", {23'd0, out_de}, 24'd0);
      check("R1 pix under reset", out_pix, 24'd0);
      tg_de = 1'b0; rst_n = 1'b1;
      tick();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule